// File: doc/BRIEF.md
# Delayed Read Transaction Tracker

This block sits on the target side of a bus bridge and keeps track of one delayed inbound read. A read that cannot deliver its first data word when it is first presented is answered with retry. The block captures its address and command and starts a fetch from the fabric. Until the same master returns with the same request and the fetched data is on hand, every other inbound transaction is turned away with retry.

A master might never come back for its delayed read. To keep that from locking up the bridge, each turned-away transaction is counted against a programmable budget. When the budget runs out, the delayed read is forgotten and the bridge accepts traffic again. The budget is a 3-bit code: code 0 means no limit, and code k from 1 to 7 allows 2^k rejections.

The state machine has three states:
- IDLE: no read is held.
- FETCH: a read is captured and its data has not yet arrived.
- HELD: the data has arrived and the block waits for the original master to return.

The named transitions are:
- *capture* (IDLE to FETCH)
- *arrive* (FETCH to HELD)
- *complete* (HELD to IDLE)
- *drop* (FETCH or HELD to IDLE)

The block gives its decision in the same cycle as the request. The fetch-start and discard pulses are registered, so each appears one cycle after the request that causes it.

Top module: `delayed_read_tracker`

## Requirements
- R1: After reset the tracker is in IDLE with `fetch_start` and `discard` low. No request is answered with both retry and accept, and every presented request gets exactly one of the two.
- R2: In IDLE, a request with `req_read`=1 and `first_data_done`=0 is answered with retry and captured (capture). `fetch_start` is high for exactly one cycle, in the cycle after that request.
- R3: In IDLE, a request with `first_data_done`=1, or with `req_read`=0, is accepted and not captured. A following different request is then handled as in IDLE.
- R4: While a read is held (FETCH or HELD), every request whose address or command differs from the captured one is answered with retry.
- R5: A matching request (same address and same command) presented before the data has arrived is retried and is not counted against the budget.
- R6: A one-cycle `data_ready` pulse in FETCH moves the tracker to HELD (arrive). The next matching request is then accepted, and the tracker returns to IDLE (complete).
- R7: With `limit_code` = k in 1..7, the 2^k-th counted rejection is still answered with retry, and the tracker drops the held read (drop). `discard` is high for one cycle, in the cycle after that rejection. Rejections 1 to 2^k-1 raise no `discard`.
- R8: With `limit_code` = 0, no number of rejections raises `discard` or drops the held read.
- R9: The rejection count is cleared whenever the tracker is in IDLE. A newly captured read therefore gets the full budget again, whether the previous one completed or was dropped.
- R10: A request with the captured address but a different command does not match. It is rejected and counted.
- R11: `data_ready` asserted while in IDLE has no effect. A read captured later still waits for its own `data_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An inbound request is presented this cycle |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | CMD_W | Request command |
| req_read | input | 1 | Request is a read type |
| first_data_done | input | 1 | Request can complete its first data phase now |
| data_ready | input | 1 | Fabric has delivered the fetched read data |
| limit_code | input | CODE_W | Rejection budget code (0 = unlimited, k = 2^k) |
| resp_retry | output | 1 | Answer the presented request with retry |
| resp_accept | output | 1 | Accept the presented request |
| fetch_start | output | 1 | One-cycle pulse: start the fabric fetch for a captured read |
| discard | output | 1 | One-cycle pulse: the held read was dropped |

## Verification
The assertions assume that `limit_code` stays stable while a read is held. They also assume that `req_valid` qualifies the other request fields in the same cycle and is never left floating. The stimulus changes `limit_code` only while the tracker is idle. It drives every input on the falling edge and returns `req_valid` to zero between requests, so each decision and each registered pulse can be attributed to a single request.

// File: rtl/dlyrd_pkg.sv
package dlyrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_HELD  = 2'd2
    } trk_state_t;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_CMD_W  = 4;
    localparam int unsigned DEF_CODE_W = 3;

endpackage

// File: rtl/dlyrd_capture.sv
module dlyrd_capture #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CMD_W-1:0]  cmd_in,
    output logic              match
);

    logic [ADDR_W-1:0] addr_q;
    logic [CMD_W-1:0]  cmd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
        end else if (load) begin
            addr_q <= addr_in;
            cmd_q  <= cmd_in;
        end
    end

    // both fields must agree for a returning master to be recognised
    always_comb begin
        match = (addr_in == addr_q) && (cmd_in == cmd_q);
    end

endmodule

// File: rtl/dlyrd_budget.sv
module dlyrd_budget #(
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bump,
    input  logic [CODE_W-1:0] limit_code,
    output logic              exhaust
);

    localparam int unsigned TOP_CODE  = (1 << CODE_W) - 1;
    localparam int unsigned MAX_LIMIT = 1 << TOP_CODE;
    localparam int unsigned CNT_W     = $clog2(MAX_LIMIT) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             unlimited;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        unlimited = (limit_code == '0);
        limit     = '0;
        for (int k = 1; k <= int'(TOP_CODE); k++) begin
            if (limit_code == CODE_W'(k)) begin
                limit = CNT_W'(1) << k;
            end
        end
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        exhaust = bump && !unlimited && (cnt_inc == {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (bump && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dlyrd_fsm.sv
module dlyrd_fsm
    import dlyrd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_read,
    input  logic first_data_done,
    input  logic data_ready,
    input  logic match,
    input  logic exhaust,
    output logic resp_retry,
    output logic resp_accept,
    output logic load,
    output logic bump,
    output logic clear,
    output logic fetch_start,
    output logic discard
);

    trk_state_t st_q;
    trk_state_t st_d;
    logic       fetch_d;
    logic       drop_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // decisions, strobes and next state
    always_comb begin
        st_d        = st_q;
        resp_retry  = 1'b0;
        resp_accept = 1'b0;
        load        = 1'b0;
        bump        = 1'b0;
        clear       = 1'b0;
        fetch_d     = 1'b0;
        drop_d      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                clear = 1'b1;
                if (req_valid) begin
                    if (req_read && !first_data_done) begin
                        resp_retry = 1'b1;
                        load       = 1'b1;
                        fetch_d    = 1'b1;
                        st_d       = ST_FETCH;
                    end else begin
                        resp_accept = 1'b1;
                    end
                end
            end
            ST_FETCH, ST_HELD: begin
                if (st_q == ST_FETCH && data_ready) begin
                    st_d = ST_HELD;
                end
                if (req_valid) begin
                    if (match) begin
                        if (st_q == ST_HELD) begin
                            resp_accept = 1'b1;
                            st_d        = ST_IDLE;
                        end else begin
                            resp_retry = 1'b1;
                        end
                    end else begin
                        resp_retry = 1'b1;
                        bump       = 1'b1;
                        if (exhaust) begin
                            drop_d = 1'b1;
                            st_d   = ST_IDLE;
                        end
                    end
                end
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // registered pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_start <= 1'b0;
            discard     <= 1'b0;
        end else begin
            fetch_start <= fetch_d;
            discard     <= drop_d;
        end
    end

endmodule

// File: rtl/delayed_read_tracker.sv
module delayed_read_tracker #(
    parameter int unsigned ADDR_W = dlyrd_pkg::DEF_ADDR_W,
    parameter int unsigned CMD_W  = dlyrd_pkg::DEF_CMD_W,
    parameter int unsigned CODE_W = dlyrd_pkg::DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic              req_read,
    input  logic              first_data_done,
    input  logic              data_ready,
    input  logic [CODE_W-1:0] limit_code,
    output logic              resp_retry,
    output logic              resp_accept,
    output logic              fetch_start,
    output logic              discard
);

    logic match;
    logic exhaust;
    logic load;
    logic bump;
    logic clear;

    dlyrd_capture #(
        .ADDR_W(ADDR_W),
        .CMD_W (CMD_W)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .addr_in(req_addr),
        .cmd_in (req_cmd),
        .match  (match)
    );

    dlyrd_budget #(
        .CODE_W(CODE_W)
    ) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .bump      (bump),
        .limit_code(limit_code),
        .exhaust   (exhaust)
    );

    dlyrd_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_read       (req_read),
        .first_data_done(first_data_done),
        .data_ready     (data_ready),
        .match          (match),
        .exhaust        (exhaust),
        .resp_retry     (resp_retry),
        .resp_accept    (resp_accept),
        .load           (load),
        .bump           (bump),
        .clear          (clear),
        .fetch_start    (fetch_start),
        .discard        (discard)
    );

endmodule

// File: rtl/dlyrd_checker.sv
module dlyrd_checker #(
    parameter int unsigned CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              resp_retry,
    input logic              resp_accept,
    input logic              fetch_start,
    input logic              discard,
    input logic [CODE_W-1:0] limit_code
);

    assert_one_answer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (resp_retry ^ resp_accept));

    assert_silent_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(resp_retry || resp_accept));

    assert_fetch_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |=> !fetch_start);

    assert_fetch_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |-> $past(req_valid && resp_retry));

    assert_discard_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> !discard);

    assert_discard_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        discard |-> $past(req_valid && resp_retry));

    assert_no_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        discard |-> ($past(limit_code) != '0));

    assert_not_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_start && discard));

endmodule

bind delayed_read_tracker dlyrd_checker #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .resp_retry (resp_retry),
    .resp_accept(resp_accept),
    .fetch_start(fetch_start),
    .discard    (discard),
    .limit_code (limit_code)
);

// File: tb/sim_delayed_read_tracker.sv
`timescale 1ns/1ps
module sim_delayed_read_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic        req_read = 1'b0;
    logic        first_data_done = 1'b0;
    logic        data_ready = 1'b0;
    logic [2:0]  limit_code = '0;
    logic        resp_retry;
    logic        resp_accept;
    logic        fetch_start;
    logic        discard;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    delayed_read_tracker u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_cmd        (req_cmd),
        .req_read       (req_read),
        .first_data_done(first_data_done),
        .data_ready     (data_ready),
        .limit_code     (limit_code),
        .resp_retry     (resp_retry),
        .resp_accept    (resp_accept),
        .fetch_start    (fetch_start),
        .discard        (discard)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // present one request; check the same-cycle decision and the next-cycle pulses
    task automatic present(input logic [31:0] a, input logic [3:0] c, input logic rd,
                           input logic fdd, input logic exp_retry, input logic exp_fetch,
                           input logic exp_disc, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_read = rd; first_data_done = fdd;
        #1;
        chk({tag, " retry"}, resp_retry, exp_retry);
        chk({tag, " accept"}, resp_accept, !exp_retry);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " fetch_start"}, fetch_start, exp_fetch);
        chk({tag, " discard"}, discard, exp_disc);
    endtask

    task automatic pulse_ready();
        @(negedge clk); data_ready = 1'b1;
        @(negedge clk); data_ready = 1'b0;
    endtask

    localparam logic [31:0] A = 32'h0000_1000;
    localparam logic [31:0] B = 32'h0000_2040;

    task automatic t_reset_R1();
        chk("R1 fetch_start at reset", fetch_start, 1'b0);
        chk("R1 discard at reset", discard, 1'b0);
        chk("R1 no answer without request", resp_retry | resp_accept, 1'b0);
    endtask

    task automatic t_idle_accept_R3();
        present(A, 4'h6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 read with first data");
        present(A, 4'h7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 write in idle");
        present(B, 4'h6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 still idle");
    endtask

    task automatic t_complete_R6();
        limit_code = 3'd0;
        present(A, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R2 capture");
        @(negedge clk);
        chk("R2 fetch_start one cycle", fetch_start, 1'b0);
        present(B, 4'h6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 other read");
        present(B, 4'h7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 other write");
        present(A, 4'h6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 match before data");
        pulse_ready();
        present(A, 4'h6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 match after data");
        present(B, 4'h6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 back in idle");
    endtask

    task automatic t_limits_R7();
        for (int k = 1; k <= 7; k++) begin
            int n;
            n = 1 << k;
            limit_code = 3'(k);
            present(A, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7 capture");
            for (int i = 0; i < n - 1; i++) begin
                present(B + 32'(i), 4'h6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7 below limit");
            end
            present(B, 4'h2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R7 limit reached");
            @(negedge clk);
            chk("R7 discard one cycle", discard, 1'b0);
            present(A, 4'h6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7 idle after drop");
        end
    endtask

    task automatic t_unlimited_R8();
        limit_code = 3'd0;
        present(A, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R8 capture");
        for (int i = 0; i < 300; i++) begin
            present(B, 4'h6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 no discard");
        end
        pulse_ready();
        present(A, 4'h6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 still held and completes");
    endtask

    task automatic t_clear_R9();
        limit_code = 3'd1;
        present(A, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9 capture 1");
        present(B, 4'h6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 one rejection");
        pulse_ready();
        present(A, 4'h6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 complete");
        present(A, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9 capture 2");
        present(B, 4'h6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 count restarted");
        present(B, 4'h6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R9 full budget used");
    endtask

    task automatic t_match_not_counted_R5();
        limit_code = 3'd1;
        present(A, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5 capture");
        for (int i = 0; i < 5; i++) begin
            present(A, 4'h6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 own retry not counted");
        end
        present(B, 4'h6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 first real rejection");
        present(B, 4'h6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R5 second real rejection");
    endtask

    task automatic t_cmd_mismatch_R10();
        limit_code = 3'd1;
        present(A, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R10 capture");
        pulse_ready();
        present(A, 4'h7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10 other command retried");
        present(A, 4'h7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R10 other command counted");
    endtask

    task automatic t_idle_ready_R11();
        limit_code = 3'd0;
        pulse_ready();
        present(A, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R11 capture");
        present(A, 4'h6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R11 idle ready ignored");
        pulse_ready();
        present(A, 4'h6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11 own ready completes");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_R1();
        @(negedge clk);
        rst_n = 1'b1;
        t_idle_accept_R3();
        t_complete_R6();
        t_match_not_counted_R5();
        t_cmd_mismatch_R10();
        t_limits_R7();
        t_unlimited_R8();
        t_clear_R9();
        t_idle_ready_R11();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule